// File: doc/BRIEF.md
# Variable-Duration Instruction Sequencer

This block steps a program counter through a fixed, read-only microcode store and presents the selected instruction word on its output. Every instruction stays current for a number of base clock cycles that the instruction itself chooses through a small divide field in its low bits. The program counter therefore advances at a rate that changes from one instruction to the next.

On the last base cycle of each instruction period the block raises an end strobe for exactly one cycle. Downstream registers use this strobe as a clock enable to load their next values, so the whole datapath stays in the single base clock domain. The store contents are computed inside the design from a fixed formula, so no external file is needed. Decoding of the remaining instruction bits is left to the surrounding logic.

Top module: `instr_seq_top`

## Requirements
- R1: While the synchronous reset `rst` is high at a rising edge, the program counter is set to 0 and the duration count restarts, so after release the instruction at address 0 runs for its full period.
- R2: `instr_o` always equals the store word at address `pc_o`: bits [63:4] are (address × 0x0F1E2D3C4B5A697) modulo 2^60 and bits [3:0] are (5 × address + 3) modulo 16.
- R3: An instruction whose divide field in bits [3:0] holds a value N from 1 to 15 stays current for exactly N base clock cycles.
- R4: A divide field of 0 is treated as 1, so that instruction lasts exactly one base clock cycle.
- R5: `end_o` is high during the last base cycle of every instruction period and low on all other cycles.
- R6: The program counter increases by exactly 1 on the rising edge at which `end_o` is high and holds its value on every other edge.
- R7: The program counter wraps from 127 to 0 after the period of the instruction at address 127.
- R8: A reset asserted in the middle of an instruction period abandons that period; the sequence restarts at address 0 with a freshly loaded duration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| instr_o | output | 64 | Instruction word at the current program counter |
| pc_o | output | 7 | Current program counter |
| end_o | output | 1 | One-cycle strobe on the last cycle of each instruction period |

## Verification
The default store formula makes the divide field cycle through all sixteen values, so two full passes over the 128 addresses try every period length from 1 to 15 and the zero case, both between short and long neighbours. Measuring how long the DUT program counter holds each value separates an off-by-one in the duration counter from a wrong zero rule, while the per-cycle strobe comparison tells a late or early strobe apart from a wrong period. The transition from 127 to 0 exposes a wrong wrap, and a reset placed in the middle of a twelve-cycle instruction shows whether the duration count is reloaded rather than carried over.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;

   // Widest word the content formula can produce
   localparam int unsigned STORE_MAX_W = 64;

   // Multiplier that spreads the address over the upper bits
   localparam logic [59:0] HI_MIX = 60'h0F1E2D3C4B5A697;

   // Content of one store location, computed from its address
   function automatic logic [STORE_MAX_W-1:0] store_word(input int unsigned addr);
      logic [59:0] hi;
      logic [3:0]  lo;
      hi = 60'(addr) * HI_MIX;
      lo = 4'((addr * 5 + 3) % 16);
      return {hi, lo};
   endfunction

endpackage

// File: rtl/instr_seq_rom.sv
module instr_seq_rom #(
   parameter int ADDR_W     = 7,
   parameter int WORD_W     = 64,
   parameter bit PRECOMPUTE = 1'b1
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int DEPTH = 1 << ADDR_W;

   if (WORD_W > int'(instr_seq_pkg::STORE_MAX_W)) begin : g_bad_width
      $error("instr_seq_rom: WORD_W exceeds content formula width");
   end

   if (PRECOMPUTE) begin : g_table
      // Constant table built once at elaboration
      logic [WORD_W-1:0] tbl [DEPTH];
      for (genvar i = 0; i < DEPTH; i++) begin : g_ent
         assign tbl[i] = WORD_W'(instr_seq_pkg::store_word(i));
      end
      assign word_o = tbl[addr_i];
   end else begin : g_func
      // Content evaluated directly from the address
      always_comb word_o = WORD_W'(instr_seq_pkg::store_word(32'(addr_i)));
   end

endmodule

// File: rtl/instr_seq_dur.sv
module instr_seq_dur #(
   parameter int DIV_W       = 4,
   parameter bit ZERO_AS_ONE = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             end_o
);
   localparam int CNT_W = DIV_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;

   // Index of the final cycle of the current period
   if (ZERO_AS_ONE) begin : g_zero_one
      always_comb last = (div_i == '0) ? '0 : (CNT_W'(div_i) - 1'b1);
   end else begin : g_zero_full
      always_comb last = (div_i == '0) ? CNT_W'((1 << DIV_W) - 1)
                                       : (CNT_W'(div_i) - 1'b1);
   end

   assign end_o = (cnt_q == last);

   always_ff @(posedge clk_i) begin
      if (rst_i)      cnt_q <= '0;
      else if (end_o) cnt_q <= '0;
      else            cnt_q <= cnt_q + 1'b1;
   end

   p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      cnt_q <= last);

   p_count_up_r3: assert property (@(posedge clk_i) disable iff (rst_i)
      !end_o |=> cnt_q == $past(cnt_q) + 1'b1);

   p_reload_r5: assert property (@(posedge clk_i) disable iff (rst_i)
      end_o |=> cnt_q == '0);

   if (ZERO_AS_ONE) begin : g_zero_chk
      p_zero_single_r4: assert property (@(posedge clk_i) disable iff (rst_i)
         (div_i == '0) |-> end_o);
   end

endmodule

// File: rtl/instr_seq_pc.sv
module instr_seq_pc #(
   parameter int PC_W = 7
) (
   input  logic            clk_i,
   input  logic            rst_i,
   input  logic            adv_i,
   output logic [PC_W-1:0] pc_o
);
   logic [PC_W-1:0] pc_q;

   always_ff @(posedge clk_i) begin
      if (rst_i)      pc_q <= '0;
      else if (adv_i) pc_q <= pc_q + 1'b1;
   end

   assign pc_o = pc_q;

   p_pc_step_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      adv_i |=> pc_q == $past(pc_q) + 1'b1);

   p_pc_hold_r6: assert property (@(posedge clk_i) disable iff (rst_i)
      !adv_i |=> $stable(pc_q));

   p_pc_wrap_r7: assert property (@(posedge clk_i) disable iff (rst_i)
      (adv_i && pc_q == {PC_W{1'b1}}) |=> pc_q == '0);

endmodule

// File: rtl/instr_seq_top.sv
module instr_seq_top #(
   parameter int PC_W        = 7,
   parameter int INSTR_W     = 64,
   parameter int DIV_W       = 4,
   parameter int DIV_LSB     = 0,
   parameter bit ZERO_AS_ONE = 1'b1,
   parameter bit PRECOMPUTE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   output logic [INSTR_W-1:0] instr_o,
   output logic [PC_W-1:0]    pc_o,
   output logic               end_o
);
   localparam int DIV_MSB = DIV_LSB + DIV_W - 1;

   if (DIV_MSB >= INSTR_W) begin : g_bad_field
      $error("instr_seq_top: divide field lies outside the instruction word");
   end
   if (PC_W < 1 || PC_W > 10) begin : g_bad_pc
      $error("instr_seq_top: PC_W must be between 1 and 10");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("instr_seq_top: DIV_W must be between 1 and 8");
   end

   logic [PC_W-1:0]    pc;
   logic [INSTR_W-1:0] word;
   logic               adv;

   instr_seq_pc #(
      .PC_W (PC_W)
   ) pc_i (
      .clk_i (clk),
      .rst_i (rst),
      .adv_i (adv),
      .pc_o  (pc)
   );

   instr_seq_rom #(
      .ADDR_W     (PC_W),
      .WORD_W     (INSTR_W),
      .PRECOMPUTE (PRECOMPUTE)
   ) rom_i (
      .addr_i (pc),
      .word_o (word)
   );

   instr_seq_dur #(
      .DIV_W       (DIV_W),
      .ZERO_AS_ONE (ZERO_AS_ONE)
   ) dur_i (
      .clk_i (clk),
      .rst_i (rst),
      .div_i (word[DIV_MSB:DIV_LSB]),
      .end_o (adv)
   );

   assign instr_o = word;
   assign pc_o    = pc;
   assign end_o   = adv;

   p_reset_pc_r1: assert property (@(posedge clk)
      rst |=> pc_o == '0);

   p_reset_restart_r8: assert property (@(posedge clk)
      (rst && word[DIV_MSB:DIV_LSB] > 1) |=> !end_o);

endmodule

// File: tb/instr_seq_top_tb_top.sv
`timescale 1ns/1ps
module instr_seq_top_tb_top;
   localparam int PC_W = 7;
   localparam int DEPTH = 128;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [63:0] instr_o;
   logic [6:0]  pc_o;
   logic        end_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   int          pc_m, cnt_m, wraps, run_len;
   logic [6:0]  prev_pc;

   always #2 clk = ~clk;

   instr_seq_top dut_i (
      .clk     (clk),
      .rst     (rst),
      .instr_o (instr_o),
      .pc_o    (pc_o),
      .end_o   (end_o)
   );

   function automatic logic [63:0] exp_word(input int a);
      logic [59:0] hi;
      hi = 60'(a) * 60'h0F1E2D3C4B5A697;
      return {hi, 4'((a * 5 + 3) % 16)};
   endfunction

   function automatic int field_of(input int a);
      return (a * 5 + 3) % 16;
   endfunction

   function automatic int eff_len(input int a);
      return (field_of(a) == 0) ? 1 : field_of(a);
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One sampled cycle: compare, then advance the model over the next edge
   task automatic step();
      chk(instr_o == exp_word(pc_m), "R2", instr_o, exp_word(pc_m));
      chk(pc_o == PC_W'(pc_m), "R6", 64'(pc_o), 64'(pc_m));
      chk(end_o == (cnt_m == eff_len(pc_m) - 1), "R5",
          64'(end_o), 64'(cnt_m == eff_len(pc_m) - 1));
      if (pc_o != prev_pc) begin
         if (field_of(int'(prev_pc)) == 0)
            chk(run_len == 1, "R4", 64'(run_len), 64'd1);
         else
            chk(run_len == eff_len(int'(prev_pc)), "R3",
                64'(run_len), 64'(eff_len(int'(prev_pc))));
         if (prev_pc == 7'd127)
            chk(pc_o == 7'd0, "R7", 64'(pc_o), 64'd0);
         prev_pc = pc_o;
         run_len = 1;
      end else begin
         run_len++;
      end
      if (cnt_m == eff_len(pc_m) - 1) begin
         cnt_m = 0;
         pc_m  = (pc_m + 1) % DEPTH;
         if (pc_m == 0) wraps++;
      end else begin
         cnt_m++;
      end
      @(negedge clk);
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state while reset is held
      chk(pc_o == 7'd0, "R1", 64'(pc_o), 64'd0);
      chk(end_o == 1'b0, "R1", 64'(end_o), 64'd0);
      chk(instr_o == exp_word(0), "R1", instr_o, exp_word(0));
      rst = 1'b0;
      pc_m = 0; cnt_m = 0; wraps = 0; run_len = 0; prev_pc = '0;
      while (wraps < 2) step();
      // Advance into the middle of the twelve-cycle instruction at address 5
      while (!(pc_m == 5 && cnt_m == 4)) step();
      rst = 1'b1;
      @(negedge clk);
      chk(pc_o == 7'd0, "R8", 64'(pc_o), 64'd0);
      chk(end_o == 1'b0, "R8", 64'(end_o), 64'd0);
      chk(instr_o == exp_word(0), "R8", instr_o, exp_word(0));
      rst = 1'b0;
      pc_m = 0; cnt_m = 0; run_len = 0; prev_pc = '0;
      // R8: fresh period at address 0 is confirmed by the run-length checks
      repeat (300) step();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

endmodule